// File: doc/BRIEF.md
# Mode-Dependent Programmer Register File

This block holds the programmer-visible registers of an 8/16-bit processor core that keeps a legacy 8-bit emulation mode: the accumulator, two index registers and a 16-bit stack pointer. It also holds the three mode flags that decide register widths (emulation, accumulator-narrow, index-narrow) and a carry bit, which the mode-exchange request swaps with the emulation flag. The sequencer of the core strobes one register operation per cycle: a load from a data bus, a register-to-register copy, or a one-byte push or pop adjustment of the stack pointer. In the same cycle it may request flag clears and sets, in the style of clear-mask/set-mask instructions, and a mode exchange.

The width rules are applied at every clock edge. The stack pointer is always moved as a full 16-bit value, but its high byte is pinned to 01h while emulation mode is active. The index high bytes read as zero whenever the index-narrow flag is set. When the accumulator is narrow, its upper byte is hidden but kept. As a result, a copy of X into the stack pointer in narrow-index native mode leaves a high byte of 00h, not 01h. Every result is registered and shows on the outputs one clock after the request.

Top module: `mode_regfile`

## Requirements
- R1: An active-low asynchronous reset gives emulation=1, accumulator-narrow=1, index-narrow=1, carry=0, accumulator=X=Y=0000h and stack pointer=01FFh.
- R2: `op_code` encodings, acted on when `op_valid`=1: 0 load A, 1 load X, 2 load Y, 3 load S, 4 X to S, 5 S to X, 6 X to Y, 7 Y to X, 8 A to X, 9 X to A, 10 A to S, 11 S to A, 12 push (S minus 1), 13 pop (S plus 1), 14 and 15 do nothing. Load A with the accumulator narrow writes only bits 7:0 and keeps bits 15:8. With the accumulator wide it writes all 16 bits.
- R3: Loads of X or Y, and S to X, write 16 bits when the index is wide. When the index is narrow they write the low byte and zero the high byte. While the index-narrow flag is 1, the high bytes of X and Y are 00h.
- R4: The copies X to Y, Y to X and A to X use only the index-narrow flag to choose their width. A to X copies all 16 bits of A when the index is wide, whatever the accumulator width.
- R5: X to A follows the accumulator width and keeps A bits 15:8 when the accumulator is narrow. S to A always copies all 16 bits.
- R6: Load S, X to S and A to S move 16 bits in native mode. In emulation mode only the low byte changes and the stack pointer high byte stays 01h.
- R7: X to S in native mode with a narrow index gives a stack pointer high byte of 00h.
- R8: In native mode, push and pop step S by one with a full 16-bit borrow or carry. In emulation mode they wrap within page 01h (0100h push gives 01FFh, 01FFh pop gives 0100h).
- R9: The `flag_clr` and `flag_set` masks use bit 2 for accumulator-narrow, bit 1 for index-narrow and bit 0 for carry. Set wins over clear. New flags show one cycle later. An operation in the same cycle uses the old flags.
- R10: In emulation mode the accumulator-narrow and index-narrow flags read 1, and clear requests for them have no effect.
- R11: A mode exchange swaps carry and emulation. On entering emulation mode, at that same edge, both width flags become 1, the index high bytes become 00h and the stack pointer high byte becomes 01h.
- R12: Setting the index-narrow flag in native mode clears the X and Y high bytes at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 4 | Register operation select |
| wr_data | input | 16 | Load data |
| flag_clr | input | 3 | Flag clear mask {acc-narrow, idx-narrow, carry} |
| flag_set | input | 3 | Flag set mask, same layout |
| xce_req | input | 1 | Exchange carry and emulation flags |
| acc_o | output | 16 | Accumulator |
| xr_o | output | 16 | X index register |
| yr_o | output | 16 | Y index register |
| sp_o | output | 16 | Stack pointer |
| emu_o | output | 1 | Emulation flag |
| accn_o | output | 1 | Accumulator-narrow flag |
| idxn_o | output | 1 | Index-narrow flag |
| cy_o | output | 1 | Carry flag |

## Verification
Every register and flag result is due exactly one clock after the cycle that carries the request, because each output comes straight from a register. The bench drives requests on the falling edge. A behavioural model updates on the rising edge, and all outputs are compared against it at the next falling edge, so each comparison lands one edge after the cause. The directed corner cases (page wrap, native narrow copy to S, entering emulation) are read at that same falling edge, after a single-cycle strobe.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

    localparam int RF_DW = 16;
    localparam int RF_BW = 8;
    localparam logic [RF_BW-1:0] RF_EMU_PAGE = 8'h01;
    localparam logic [RF_BW-1:0] RF_SP_RST_LO = 8'hFF;

    localparam int FB_ACCN = 2;
    localparam int FB_IDXN = 1;
    localparam int FB_CY   = 0;

    typedef enum logic [3:0] {
        OP_LDA  = 4'd0,
        OP_LDX  = 4'd1,
        OP_LDY  = 4'd2,
        OP_LDS  = 4'd3,
        OP_X2S  = 4'd4,
        OP_S2X  = 4'd5,
        OP_X2Y  = 4'd6,
        OP_Y2X  = 4'd7,
        OP_A2X  = 4'd8,
        OP_X2A  = 4'd9,
        OP_A2S  = 4'd10,
        OP_S2A  = 4'd11,
        OP_PUSH = 4'd12,
        OP_POP  = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } rf_op_e;

    typedef struct packed {
        logic emu;
        logic accn;
        logic idxn;
        logic cy;
    } rf_flags_t;

    typedef struct packed {
        logic [RF_DW-1:0] acc;
        logic [RF_DW-1:0] xr;
        logic [RF_DW-1:0] yr;
        logic [RF_DW-1:0] sp;
        rf_flags_t        fl;
    } rf_state_t;

endpackage

// File: rtl/mode_flags.sv
module mode_flags
    import modereg_pkg::*;
#(
    parameter int NFL = 3
) (
    input  rf_flags_t      fl_q,
    input  logic           xce_req,
    input  logic [NFL-1:0] clr_mask,
    input  logic [NFL-1:0] set_mask,
    output rf_flags_t      fl_d
);
    rf_flags_t swp;

    always_comb begin
        swp = fl_q;
        if (xce_req) begin
            swp.emu = fl_q.cy;
            swp.cy  = fl_q.emu;
        end
        fl_d      = swp;
        fl_d.accn = (swp.accn & ~clr_mask[FB_ACCN]) | set_mask[FB_ACCN];
        fl_d.idxn = (swp.idxn & ~clr_mask[FB_IDXN]) | set_mask[FB_IDXN];
        fl_d.cy   = (swp.cy   & ~clr_mask[FB_CY])   | set_mask[FB_CY];
        if (swp.emu) begin
            fl_d.accn = 1'b1;
            fl_d.idxn = 1'b1;
        end
    end
endmodule

// File: rtl/mode_index.sv
module mode_index
    import modereg_pkg::*;
#(
    parameter int DW = RF_DW,
    parameter int BW = RF_BW
) (
    input  logic          op_valid,
    input  rf_op_e        op,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] acc_q,
    input  logic [DW-1:0] xr_q,
    input  logic [DW-1:0] yr_q,
    input  logic [DW-1:0] sp_q,
    input  logic          idxn_q,
    input  logic          idxn_d,
    output logic [DW-1:0] xr_d,
    output logic [DW-1:0] yr_d
);
    localparam int HB = DW - BW;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic narrow);
        fit = narrow ? {{HB{1'b0}}, v[BW-1:0]} : v;
    endfunction

    logic [DW-1:0] xr_op, yr_op;

    always_comb begin
        xr_op = xr_q;
        yr_op = yr_q;
        if (op_valid) begin
            unique case (op)
                OP_LDX:  xr_op = fit(wr_data, idxn_q);
                OP_LDY:  yr_op = fit(wr_data, idxn_q);
                OP_S2X:  xr_op = fit(sp_q,    idxn_q);
                OP_Y2X:  xr_op = fit(yr_q,    idxn_q);
                OP_X2Y:  yr_op = fit(xr_q,    idxn_q);
                OP_A2X:  xr_op = fit(acc_q,   idxn_q);
                default: ;
            endcase
        end
        xr_d = fit(xr_op, idxn_d);
        yr_d = fit(yr_op, idxn_d);
    end
endmodule

// File: rtl/mode_stack.sv
module mode_stack
    import modereg_pkg::*;
#(
    parameter int DW = RF_DW,
    parameter int BW = RF_BW,
    parameter logic [RF_BW-1:0] PAGE = RF_EMU_PAGE
) (
    input  logic          op_valid,
    input  rf_op_e        op,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] acc_q,
    input  logic [DW-1:0] xr_q,
    input  logic [DW-1:0] sp_q,
    input  logic          emu_q,
    input  logic          emu_d,
    output logic [DW-1:0] sp_d
);
    localparam int HB = DW - BW;

    logic [DW-1:0] sp_op, sp_dec, sp_inc;
    logic [BW-1:0] lo_dec, lo_inc;

    always_comb begin
        lo_dec = sp_q[BW-1:0] - 1'b1;
        lo_inc = sp_q[BW-1:0] + 1'b1;
        if (emu_q) begin
            sp_dec = {sp_q[DW-1:BW], lo_dec};
            sp_inc = {sp_q[DW-1:BW], lo_inc};
        end else begin
            sp_dec = sp_q - 1'b1;
            sp_inc = sp_q + 1'b1;
        end
        sp_op = sp_q;
        if (op_valid) begin
            unique case (op)
                OP_LDS:  sp_op = wr_data;
                OP_X2S:  sp_op = xr_q;
                OP_A2S:  sp_op = acc_q;
                OP_PUSH: sp_op = sp_dec;
                OP_POP:  sp_op = sp_inc;
                default: ;
            endcase
        end
        sp_d = emu_d ? {{(HB-BW){1'b0}}, PAGE, sp_op[BW-1:0]} : sp_op;
    end
endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
    import modereg_pkg::*;
#(
    parameter int DW = RF_DW,
    parameter int BW = RF_BW,
    parameter int NFL = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [DW-1:0]  wr_data,
    input  logic [NFL-1:0] flag_clr,
    input  logic [NFL-1:0] flag_set,
    input  logic           xce_req,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  xr_o,
    output logic [DW-1:0]  yr_o,
    output logic [DW-1:0]  sp_o,
    output logic           emu_o,
    output logic           accn_o,
    output logic           idxn_o,
    output logic           cy_o
);
    localparam int HB = DW - BW;

    rf_op_e    op;
    rf_state_t st_q, st_d;
    rf_flags_t fl_d;
    logic [DW-1:0] xr_d, yr_d, sp_d;

    assign op = rf_op_e'(op_code);

    mode_flags #(.NFL(NFL)) u_flags (
        .fl_q     (st_q.fl),
        .xce_req  (xce_req),
        .clr_mask (flag_clr),
        .set_mask (flag_set),
        .fl_d     (fl_d)
    );

    mode_index #(.DW(DW), .BW(BW)) u_index (
        .op_valid (op_valid),
        .op       (op),
        .wr_data  (wr_data),
        .acc_q    (st_q.acc),
        .xr_q     (st_q.xr),
        .yr_q     (st_q.yr),
        .sp_q     (st_q.sp),
        .idxn_q   (st_q.fl.idxn),
        .idxn_d   (fl_d.idxn),
        .xr_d     (xr_d),
        .yr_d     (yr_d)
    );

    mode_stack #(.DW(DW), .BW(BW), .PAGE(RF_EMU_PAGE)) u_stack (
        .op_valid (op_valid),
        .op       (op),
        .wr_data  (wr_data),
        .acc_q    (st_q.acc),
        .xr_q     (st_q.xr),
        .sp_q     (st_q.sp),
        .emu_q    (st_q.fl.emu),
        .emu_d    (fl_d.emu),
        .sp_d     (sp_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fl  = fl_d;
        st_d.xr  = xr_d;
        st_d.yr  = yr_d;
        st_d.sp  = sp_d;
        if (op_valid) begin
            unique case (op)
                OP_LDA: st_d.acc = st_q.fl.accn ? {st_q.acc[DW-1:BW], wr_data[BW-1:0]} : wr_data;
                OP_X2A: st_d.acc = st_q.fl.accn ? {st_q.acc[DW-1:BW], st_q.xr[BW-1:0]} : st_q.xr;
                OP_S2A: st_d.acc = st_q.sp;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
            st_q.xr  <= '0;
            st_q.yr  <= '0;
            st_q.sp  <= {{(HB-BW){1'b0}}, RF_EMU_PAGE, RF_SP_RST_LO};
            st_q.fl  <= '{emu: 1'b1, accn: 1'b1, idxn: 1'b1, cy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign xr_o   = st_q.xr;
    assign yr_o   = st_q.yr;
    assign sp_o   = st_q.sp;
    assign emu_o  = st_q.fl.emu;
    assign accn_o = st_q.fl.accn;
    assign idxn_o = st_q.fl.idxn;
    assign cy_o   = st_q.fl.cy;

    AST_EMU_WIDTH_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        emu_o |-> (accn_o && idxn_o)); // R10

    AST_IDX_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        idxn_o |-> (xr_o[DW-1:BW] == '0 && yr_o[DW-1:BW] == '0)); // R3

    AST_EMU_SP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        emu_o |-> (sp_o[DW-1:BW] == {{(HB-BW){1'b0}}, RF_EMU_PAGE})); // R6

    AST_NATIVE_NARROW_X2S: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_X2S && !emu_o && idxn_o && !xce_req)
        |=> (sp_o[DW-1:BW] == '0)); // R7

    AST_ACC_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_LDA && accn_o)
        |=> (acc_o[DW-1:BW] == $past(acc_o[DW-1:BW]))); // R2

    AST_EMU_PUSH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_PUSH && emu_o && !xce_req)
        |=> (sp_o[BW-1:0] == $past(sp_o[BW-1:0]) - 1'b1)); // R8

    AST_XCE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (xce_req && flag_clr == '0 && flag_set == '0)
        |=> (emu_o == $past(cy_o) && cy_o == $past(emu_o))); // R11

endmodule

// File: tb/mode_regfile_tb.sv
module mode_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd14;
    logic [15:0] wr_data = '0;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  flag_set = '0;
    logic        xce_req = 1'b0;
    logic [15:0] acc_o, xr_o, yr_o, sp_o;
    logic        emu_o, accn_o, idxn_o, cy_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    int ma, mx, my, ms, me, mm, mi, mc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_data(wr_data), .flag_clr(flag_clr), .flag_set(flag_set), .xce_req(xce_req),
        .acc_o(acc_o), .xr_o(xr_o), .yr_o(yr_o), .sp_o(sp_o),
        .emu_o(emu_o), .accn_o(accn_o), .idxn_o(idxn_o), .cy_o(cy_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int nar(input int v, input int narrow);
        return narrow ? (v & 'hFF) : (v & 'hFFFF);
    endfunction

    // behavioural reference: old flags drive the operation, new flags force afterwards
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma = 0; mx = 0; my = 0; ms = 'h01FF; me = 1; mm = 1; mi = 1; mc = 0;
        end else begin
            int d, ne, nc;
            d = int'(wr_data);
            if (op_valid) begin
                case (op_code)
                    0:  ma = mm ? ((ma & 'hFF00) | (d & 'hFF)) : d;
                    1:  mx = nar(d, mi);
                    2:  my = nar(d, mi);
                    3:  ms = d;
                    4:  ms = mx;
                    5:  mx = nar(ms, mi);
                    6:  my = nar(mx, mi);
                    7:  mx = nar(my, mi);
                    8:  mx = nar(ma, mi);
                    9:  ma = mm ? ((ma & 'hFF00) | (mx & 'hFF)) : mx;
                    10: ms = ma;
                    11: ma = ms;
                    12: ms = me ? ('h0100 | ((ms - 1) & 'hFF)) : ((ms - 1) & 'hFFFF);
                    13: ms = me ? ('h0100 | ((ms + 1) & 'hFF)) : ((ms + 1) & 'hFFFF);
                    default: ;
                endcase
            end
            ne = xce_req ? mc : me;
            nc = xce_req ? me : mc;
            me = ne;
            mm = (flag_set[2] || (mm && !flag_clr[2])) ? 1 : 0;
            mi = (flag_set[1] || (mi && !flag_clr[1])) ? 1 : 0;
            mc = (flag_set[0] || (nc && !flag_clr[0])) ? 1 : 0;
            if (me) begin mm = 1; mi = 1; ms = 'h0100 | (ms & 'hFF); end
            if (mi) begin mx = mx & 'hFF; my = my & 'hFF; end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 acc vs model", int'(acc_o), ma);
            chk("R3 x vs model", int'(xr_o), mx);
            chk("R4 y vs model", int'(yr_o), my);
            chk("R8 sp vs model", int'(sp_o), ms);
            chk("R9 flags vs model", {emu_o, accn_o, idxn_o, cy_o}, {me[0], mm[0], mi[0], mc[0]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int code, input int d, input int clr, input int set, input bit xce);
        @(negedge clk);
        op_valid = (code < 16); op_code = code[3:0]; wr_data = d[15:0];
        flag_clr = clr[2:0]; flag_set = set[2:0]; xce_req = xce;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd14; flag_clr = '0; flag_set = '0; xce_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 reset sp", int'(sp_o), 'h01FF);
        chk("R1 reset flags", {emu_o, accn_o, idxn_o, cy_o}, 4'b1110);
        chk("R1 reset acc", int'(acc_o), 0);

        step(1, 'h1234, 0, 0, 0);  chk("R3 emu narrow load x", int'(xr_o), 'h0034);
        step(4, 0, 0, 0, 0);       chk("R6 emu x to s", int'(sp_o), 'h0134);
        step(3, 'hBE00, 0, 0, 0);  chk("R6 emu load s", int'(sp_o), 'h0100);
        step(12, 0, 0, 0, 0);      chk("R8 emu push wrap", int'(sp_o), 'h01FF);
        step(13, 0, 0, 0, 0);      chk("R8 emu pop wrap", int'(sp_o), 'h0100);
        step(16, 0, 'b110, 0, 0);  chk("R10 emu clear ignored", {accn_o, idxn_o}, 2'b11);
        step(16, 0, 0, 0, 1);      chk("R11 exchange to native", {emu_o, cy_o}, 2'b01);
        chk("R11 native sp kept", int'(sp_o), 'h0100);
        step(16, 0, 'b110, 0, 0);  chk("R9 clear widths", {accn_o, idxn_o}, 2'b00);
        step(1, 'h1234, 0, 0, 0);  chk("R3 wide load x", int'(xr_o), 'h1234);
        step(0, 'hABCD, 0, 0, 0);  chk("R2 wide load a", int'(acc_o), 'hABCD);
        step(8, 0, 0, 0, 0);       chk("R4 a to x wide", int'(xr_o), 'hABCD);
        step(1, 'h1234, 'b100, 'b100, 0); chk("R9 set wins over clear", int'(accn_o), 1);
        chk("R9 op uses old width", int'(xr_o), 'h1234);
        step(0, 'h0011, 0, 0, 0);  chk("R2 narrow acc keeps high", int'(acc_o), 'hAB11);
        step(9, 0, 0, 0, 0);       chk("R5 x to a narrow", int'(acc_o), 'hAB34);
        step(4, 0, 0, 0, 0);       chk("R6 native x to s", int'(sp_o), 'h1234);
        step(3, 'h0100, 0, 0, 0);  step(12, 0, 0, 0, 0);
        chk("R8 native push borrow", int'(sp_o), 'h00FF);
        step(13, 0, 0, 0, 0);      chk("R8 native pop carry", int'(sp_o), 'h0100);
        step(6, 0, 0, 0, 0);       chk("R4 x to y wide", int'(yr_o), 'h1234);
        step(16, 0, 0, 'b010, 0);  chk("R12 narrow clears x high", int'(xr_o), 'h0034);
        chk("R12 narrow clears y high", int'(yr_o), 'h0034);
        step(4, 0, 0, 0, 0);       chk("R7 native narrow x to s", int'(sp_o), 'h0034);
        step(11, 0, 0, 0, 0);      chk("R5 s to a full", int'(acc_o), 'h0034);
        step(3, 'h5678, 0, 0, 0);  step(5, 0, 0, 0, 0);
        chk("R3 s to x narrow", int'(xr_o), 'h0078);
        step(16, 0, 'b100, 'b001, 0);
        step(10, 0, 0, 0, 1);
        chk("R11 exchange to emu", {emu_o, accn_o, idxn_o, cy_o}, 4'b1110);
        chk("R11 emu page forced", int'(sp_o), 'h0134);

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            op_valid = ($urandom_range(0, 3) != 0);
            op_code  = 4'($urandom_range(0, 15));
            wr_data  = 16'($urandom);
            flag_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
            flag_set = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b0;
            xce_req  = ($urandom_range(0, 7) == 0);
        end
        @(negedge clk);
        op_valid = 1'b0; flag_clr = '0; flag_set = '0; xce_req = 1'b0;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule